// File: doc/BRIEF.md
# Bit-Serial Interleaved Modular Multiplier

This unit forms the product of two field elements modulo an odd or even modulus n, without ever building a double-width product. On each issue it fetches three register indices' contents (multiplicand, multiplier, modulus) through a single read port. It then walks the multiplier from its top bit down to bit zero. Each step doubles the running value, adds the multiplicand when the current multiplier bit is one, and pulls the value back below n with at most two conditional subtractions. The finished residue goes out through a single-cycle write port to the destination register.

Issue uses a valid/ready handshake. A request is taken on a clock edge where both valid and ready are high. While the unit is working, ready and error stay low. An operation whose modulus is zero, or whose operand or modulus has its top (sign) bit set, finishes early with the error flag raised and writes nothing. Every step takes the same three cycles whatever the data, so the latency depends only on the operand width.

Top module: `mmul_serial`

## Requirements
- R1: After synchronous reset, req_ready is 1, req_err is 0 and wr_en is 0.
- R2: A request is accepted on a rising edge with req_valid and req_ready both 1. From the next cycle until completion, req_ready and req_err are 0, and further requests (including changed indices) have no effect on the running operation.
- R3: rd_addr presents the multiplicand index, then the multiplier index, then the modulus index, one per cycle, in the three cycles that follow acceptance. rd_data is expected combinationally in the same cycle (asynchronous read).
- R4: For 0 ≤ A, B < n with n ≠ 0 and all values below 2^(WIDTH-1), the unit writes (A·B) mod n to the destination index with wr_en high for exactly one cycle.
- R5: wr_en is high in the cycle that starts 3 + 3·WIDTH rising edges after the acceptance edge, and req_ready returns to 1 in that same cycle.
- R6: If n is zero, or bit WIDTH-1 of A, B or n is 1, req_err becomes 1 and req_ready becomes 1 three edges after acceptance, and wr_en stays 0 for that operation.
- R7: req_err, once set, holds until the next accepted request, and it is 0 from the cycle after that acceptance.
- R8: The running value is below n at the start of every step and at most 3n − 3 right after the double-and-add.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_err | output | 1 | Last operation rejected its operands |
| req_src_a | input | REG_AW | Register index of the multiplicand |
| req_src_b | input | REG_AW | Register index of the multiplier |
| req_src_n | input | REG_AW | Register index of the modulus |
| req_dst | input | REG_AW | Register index for the result |
| rd_addr | output | REG_AW | Register read address |
| rd_data | input | WIDTH | Register read data, same cycle as rd_addr |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | REG_AW | Result write address |
| wr_data | output | WIDTH | Result value |

## Verification
The reduction assertions rely on the caller's promise that both operands are already smaller than the modulus. Without that promise, two subtractions no longer bound the value below n. The stimulus enumerates, for a small width, every modulus that passes the checks together with every operand pair below it, so that promise is always kept on the arithmetic path. Operand sets that break the sign or zero rules are sent only to see the early rejection, which stops before any step runs.

// File: rtl/mmul_pkg.sv
package mmul_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD_A = 3'd1,
    ST_RD_B = 3'd2,
    ST_RD_N = 3'd3,
    ST_STEP = 3'd4,
    ST_SUB1 = 3'd5,
    ST_SUB2 = 3'd6
  } mm_state_t;
endpackage

// File: rtl/mmul_condsub.sv
module mmul_condsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH+1:0] x_in,
  input  logic [WIDTH-1:0] mod_in,
  output logic [WIDTH+1:0] y_out,
  output logic             took
);
  logic [WIDTH+1:0] mod_ext;
  assign mod_ext = {2'b00, mod_in};
  assign took    = (x_in >= mod_ext);
  assign y_out   = took ? (x_in - mod_ext) : x_in;
endmodule

// File: rtl/mmul_datapath.sv
module mmul_datapath #(
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rd_data,
  input  logic             ld_a,
  input  logic             ld_b,
  input  logic             ld_n,
  input  logic             step_en,
  input  logic             sub_en,
  input  logic [CNT_W-1:0] bit_idx,
  output logic             sign_bad,
  output logic [WIDTH-1:0] res_next
);
  localparam int ACC_W = WIDTH + 2;

  logic [WIDTH-1:0] opa, opb, modn;
  logic [ACC_W-1:0] acc, addend, dbl_sum, sub_y, tri_n;
  logic             sub_took;

  assign addend   = opb[bit_idx] ? {2'b00, opa} : '0;
  assign dbl_sum  = {acc[ACC_W-2:0], 1'b0} + addend;
  assign sign_bad = opa[WIDTH-1] | opb[WIDTH-1];
  assign res_next = sub_y[WIDTH-1:0];
  assign tri_n    = {1'b0, modn, 1'b0} + {2'b00, modn};

  mmul_condsub #(.WIDTH(WIDTH)) u_sub (
    .x_in  (acc),
    .mod_in(modn),
    .y_out (sub_y),
    .took  (sub_took)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opa  <= '0;
      opb  <= '0;
      modn <= '0;
      acc  <= '0;
    end else begin
      if (ld_a) opa <= rd_data;
      if (ld_b) opb <= rd_data;
      if (ld_n) begin
        modn <= rd_data;
        acc  <= '0;
      end else if (step_en) begin
        acc <= dbl_sum;
      end else if (sub_en) begin
        acc <= sub_y;
      end
    end
  end

  // R8: every step starts from a fully reduced value
  a_r8_acc_reduced: assert property (@(posedge clk) disable iff (rst)
    step_en |-> (acc < {2'b00, modn}));

  // R8: double-and-add result stays within two subtractions of the range
  a_r8_step_bound: assert property (@(posedge clk) disable iff (rst)
    $past(step_en) |-> ((acc + ACC_W'(3)) <= tri_n));
endmodule

// File: rtl/mmul_ctrl.sv
module mmul_ctrl
  import mmul_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int REG_AW = 4,
  parameter int CNT_W  = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              req_err,
  input  logic [REG_AW-1:0] req_src_a,
  input  logic [REG_AW-1:0] req_src_b,
  input  logic [REG_AW-1:0] req_src_n,
  input  logic [REG_AW-1:0] req_dst,
  output logic [REG_AW-1:0] rd_addr,
  input  logic [WIDTH-1:0]  rd_data,
  input  logic              sign_bad,
  input  logic [WIDTH-1:0]  res_next,
  output logic              wr_en,
  output logic [REG_AW-1:0] wr_addr,
  output logic [WIDTH-1:0]  wr_data,
  output logic              ld_a,
  output logic              ld_b,
  output logic              ld_n,
  output logic              step_en,
  output logic              sub_en,
  output logic [CNT_W-1:0]  bit_idx
);
  mm_state_t         state;
  logic [REG_AW-1:0] idx_b_q, idx_n_q, dst_q;
  logic              n_bad;

  assign ld_a    = (state == ST_RD_A);
  assign ld_b    = (state == ST_RD_B);
  assign ld_n    = (state == ST_RD_N);
  assign step_en = (state == ST_STEP);
  assign sub_en  = (state == ST_SUB1) || (state == ST_SUB2);
  assign n_bad   = (rd_data == '0) || rd_data[WIDTH-1] || sign_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ready <= 1'b1;
      req_err   <= 1'b0;
      rd_addr   <= '0;
      idx_b_q   <= '0;
      idx_n_q   <= '0;
      dst_q     <= '0;
      bit_idx   <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            req_ready <= 1'b0;
            req_err   <= 1'b0;
            rd_addr   <= req_src_a;
            idx_b_q   <= req_src_b;
            idx_n_q   <= req_src_n;
            dst_q     <= req_dst;
            state     <= ST_RD_A;
          end
        end
        ST_RD_A: begin
          rd_addr <= idx_b_q;
          state   <= ST_RD_B;
        end
        ST_RD_B: begin
          rd_addr <= idx_n_q;
          state   <= ST_RD_N;
        end
        ST_RD_N: begin
          if (n_bad) begin
            req_err   <= 1'b1;
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            bit_idx <= CNT_W'(WIDTH - 1);
            state   <= ST_STEP;
          end
        end
        ST_STEP: state <= ST_SUB1;
        ST_SUB1: state <= ST_SUB2;
        ST_SUB2: begin
          if (bit_idx == '0) begin
            wr_en     <= 1'b1;
            wr_addr   <= dst_q;
            wr_data   <= res_next;
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            bit_idx <= bit_idx - 1'b1;
            state   <= ST_STEP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: handshake outputs stay quiet while an operation runs
  a_r2_busy_quiet: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (!req_ready && !req_err));

  // R4: the write strobe lasts a single cycle
  a_r4_single_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R6: a rejected operation never writes
  a_r6_no_write_on_err: assert property (@(posedge clk) disable iff (rst)
    req_err |-> !wr_en);

  // R5: ready comes back together with the result strobe
  a_r5_ready_with_write: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |-> req_ready);
endmodule

// File: rtl/mmul_serial.sv
module mmul_serial #(
  parameter int WIDTH  = 16,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              req_err,
  input  logic [REG_AW-1:0] req_src_a,
  input  logic [REG_AW-1:0] req_src_b,
  input  logic [REG_AW-1:0] req_src_n,
  input  logic [REG_AW-1:0] req_dst,
  output logic [REG_AW-1:0] rd_addr,
  input  logic [WIDTH-1:0]  rd_data,
  output logic              wr_en,
  output logic [REG_AW-1:0] wr_addr,
  output logic [WIDTH-1:0]  wr_data
);
  localparam int CNT_W = $clog2(WIDTH);

  logic             ld_a, ld_b, ld_n, step_en, sub_en, sign_bad;
  logic [CNT_W-1:0] bit_idx;
  logic [WIDTH-1:0] res_next;

  mmul_ctrl #(.WIDTH(WIDTH), .REG_AW(REG_AW), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_err  (req_err),
    .req_src_a(req_src_a),
    .req_src_b(req_src_b),
    .req_src_n(req_src_n),
    .req_dst  (req_dst),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .sign_bad (sign_bad),
    .res_next (res_next),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ld_a     (ld_a),
    .ld_b     (ld_b),
    .ld_n     (ld_n),
    .step_en  (step_en),
    .sub_en   (sub_en),
    .bit_idx  (bit_idx)
  );

  mmul_datapath #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .rd_data (rd_data),
    .ld_a    (ld_a),
    .ld_b    (ld_b),
    .ld_n    (ld_n),
    .step_en (step_en),
    .sub_en  (sub_en),
    .bit_idx (bit_idx),
    .sign_bad(sign_bad),
    .res_next(res_next)
  );
endmodule

// File: tb/tb_mmul_serial.sv
module tb_mmul_serial;
  localparam int W  = 5;
  localparam int AW = 3;
  localparam int LAT = 3 + 3 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready, req_err;
  logic [AW-1:0] src_a = '0, src_b = '0, src_n = '0, dst = '0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [W-1:0]  rd_data, wr_data;
  logic          wr_en;

  logic [W-1:0]  rf [8];
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [W-1:0]  ld_data = '0;

  int vec_cnt = 0;
  int miss_cnt = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  assign rd_data = rf[rd_addr];

  always @(posedge clk) begin
    if (wr_en) rf[wr_addr] <= wr_data;
    else if (ld_en) rf[ld_addr] <= ld_data;
  end

  mmul_serial #(.WIDTH(W), .REG_AW(AW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_err(req_err), .req_src_a(src_a), .req_src_b(src_b),
    .req_src_n(src_n), .req_dst(dst), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec_cnt++;
    if (!ok) begin
      miss_cnt++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input int addr, input int val);
    @(negedge clk);
    ld_en = 1'b1;
    ld_addr = AW'(addr);
    ld_data = W'(val);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_op(input int a, input int b, input int n, input int d,
                        input bit exp_err, input bit hold);
    int cnt;
    bit done;
    bit wrote;
    load(1, a);
    load(2, b);
    load(3, n);
    @(negedge clk);
    req_valid = 1'b1;
    src_a = 3'd1; src_b = 3'd2; src_n = 3'd3; dst = AW'(d);
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    chk(rd_addr == 3'd1, "R3 first read index", int'(rd_addr), 1);
    chk(!req_ready && !req_err, "R2/R7 quiet after accept",
        int'({req_ready, req_err}), 0);
    cnt = 0;
    done = 1'b0;
    wrote = 1'b0;
    while (!done && cnt < 100) begin
      @(negedge clk);
      cnt++;
      if (hold) begin
        if (cnt < 6) begin
          src_a = 3'd5; src_b = 3'd5; dst = 3'd6;
        end else begin
          req_valid = 1'b0;
        end
      end
      if (cnt == 1) chk(rd_addr == 3'd2, "R3 second read index", int'(rd_addr), 2);
      if (cnt == 2) chk(rd_addr == 3'd3, "R3 third read index", int'(rd_addr), 3);
      if (wr_en) wrote = 1'b1;
      if (req_ready) done = 1'b1;
    end
    if (exp_err) begin
      chk(cnt == 3, "R6 error timing", cnt, 3);
      chk(req_err == 1'b1, "R6 error flag", int'(req_err), 1);
      chk(!wrote, "R6 no write", int'(wrote), 0);
    end else begin
      chk(cnt == LAT, "R5 latency", cnt, LAT);
      chk(wrote && wr_en, "R4 write strobe", int'(wr_en), 1);
      chk(int'(wr_data) == (a * b) % n, "R4 product residue", int'(wr_data), (a * b) % n);
      chk(int'(wr_addr) == d, "R4/R2 destination", int'(wr_addr), d);
      chk(!req_err, "R6 no error on valid operands", int'(req_err), 0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miss_cnt++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(req_err == 1'b0, "R1 err after reset", int'(req_err), 0);
    chk(wr_en == 1'b0, "R1 no write after reset", int'(wr_en), 0);

    // R2: request held and altered while busy must not disturb the running one
    run_op(13, 11, 15, 4, 1'b0, 1'b1);
    @(negedge clk);
    chk(!wr_en, "R4 single-cycle strobe", int'(wr_en), 0);

    // R6 and R7: rejection cases and persistence of the flag
    run_op(0, 0, 0, 4, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk(req_err == 1'b1, "R7 err held while idle", int'(req_err), 1);
    run_op(1, 1, 16, 4, 1'b1, 1'b0);
    run_op(17, 2, 5, 4, 1'b1, 1'b0);
    run_op(2, 20, 3, 4, 1'b1, 1'b0);
    run_op(0, 0, 31, 4, 1'b1, 1'b0);

    // R4/R5/R8: every legal modulus and operand pair at this width
    for (int n = 1; n < 16; n++)
      for (int a = 0; a < n; a++)
        for (int b = 0; b < n; b++)
          run_op(a, b, n, (a + b) % 8, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end
endmodule